// File: doc/BRIEF.md
# Disk Bus Command Phase Sequencer

This block drives one complete command across a selection-based disk controller bus from the host end. After a start pulse it raises a one-cycle select request, drives the transfer mode onto the bus, and waits for the controller to report that it is selected. From then on, each time the controller signals ready, the block looks at two phase lines and does one of four things: it sends the next command byte, it sends a data byte, it takes in a data byte, or it reads the final status byte. After the status byte it waits for the controller to release the selection.

A status byte with its error bit set starts a sense exchange at once, with no action from the user. This exchange is a six-byte command addressed to the logical unit named in the status, run in programmed-I/O mode. The four bytes it returns are kept for the user. Every wait has a timeout counter that reloads from the `tmo` input each time a new wait begins. In DMA mode a data phase does not move bytes through the block. The block holds a request to an external DMA engine until that engine signals completion.

Top module: `disk_bus_sequencer`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `sense_fail`, `bus_sel`, `bus_wr`, `bus_rd`, `dma_req` and `bus_dma_en` are all 0.
- R2: A `start` pulse in idle gives exactly one one-cycle `bus_sel` pulse and drives `bus_dma_en` to the value of `dma_mode`. If `st_sel` does not rise within `tmo` cycles, the command ends with result 1 (timeout).
- R3: A byte moves only while `st_rdy` is high. If `st_rdy` stays low for `tmo` cycles at any wait point, the command ends with result 1.
- R4: Phase code {`st_cd`,`st_io`} = 2'b10 sends a command byte. Byte i is taken from `cmd_bytes[8i+7:8i]`, in order. The command is 6 bytes long when `cmd_long`=0 and 14 bytes when it is 1. Any command phase after the last byte sends 0x00.
- R5: In programmed-I/O mode, phase 2'b00 sends `src_byte` and pulses `src_take` when `src_en`=1. When `src_en`=0 it sends 0x00 and does not pulse `src_take`.
- R6: In programmed-I/O mode, phase 2'b01 reads one byte. When `sink_en`=1 the byte appears on `sink_byte` with a `sink_valid` pulse. When `sink_en`=0 the byte is discarded and `sink_valid` stays low.
- R7: In DMA mode, phase 2'b00 or 2'b01 raises `dma_req` and holds it until `dma_irq`. No `bus_wr` or `bus_rd` strobe occurs for that phase.
- R8: Phase 2'b11 reads one status byte, then waits for `st_sel` to fall, with the same timeout rule. With status bit 1 clear, the result is 0. `result` is never 3.
- R9: With status bit 1 set, a sense command runs next: a new select, then six command bytes 0x03, {status[7:5],5'b0}, 0, 0, 0, 0, in programmed-I/O mode. Its first four data-in bytes go to `sense_data`, byte k at bits 8k+7:8k, and are not sent to `sink_byte`. The outer result is 2.
- R10: If the sense command times out or returns status bit 1 set, no further sense runs, the result is 2, and `sense_fail`=1. A timeout of the outer command leaves `sense_fail`=0.
- R11: `done` is a single-cycle pulse, `busy` is low while `done` is high, and at most one of `bus_sel`, `bus_wr`, `bus_rd` is high in any cycle.
- R12: The timeout counter restarts at every wait point. A command whose individual waits are each shorter than `tmo` completes, however long the whole command lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (sampled in idle) |
| dma_mode | input | 1 | 1 = data phases handled by external DMA |
| cmd_long | input | 1 | 1 = 14-byte command, 0 = 6-byte command |
| cmd_bytes | input | CMD_MAX*8 | Command bytes, byte i at bits 8i+7:8i |
| tmo | input | TW | Cycles allowed at each wait point |
| src_en | input | 1 | A data source is present |
| src_byte | input | 8 | Next outgoing data byte |
| src_take | output | 1 | Pulse: `src_byte` was sent |
| sink_en | input | 1 | A data sink is present |
| sink_byte | output | 8 | Received data byte |
| sink_valid | output | 1 | Pulse: `sink_byte` is new |
| busy | output | 1 | Command in progress |
| done | output | 1 | Pulse: command finished |
| result | output | 2 | 0 ok, 1 timeout, 2 controller error |
| sense_fail | output | 1 | Automatic sense command failed |
| sense_data | output | 32 | Four sense bytes, byte k at bits 8k+7:8k |
| bus_sel | output | 1 | Select request pulse |
| bus_dma_en | output | 1 | Transfer mode driven to the controller |
| bus_wr | output | 1 | Write strobe for `bus_wdata` |
| bus_wdata | output | 8 | Byte to the controller |
| bus_rd | output | 1 | Read acknowledge strobe |
| bus_rdata | input | 8 | Byte from the controller |
| st_sel | input | 1 | Controller selected |
| st_rdy | input | 1 | Controller ready for a byte |
| st_cd | input | 1 | Phase line: command/status |
| st_io | input | 1 | Phase line: toward host |
| dma_req | output | 1 | DMA data phase request |
| dma_irq | input | 1 | DMA data phase complete |

## Verification
A wrong phase decode or a command index that advances wrongly shows up on `bus_wdata` at the very next `bus_wr`. The controller model logs every byte, so the bad byte is caught in the same command. A timer that fails to reload or a lost wait state makes the command end early with result 1, or never end, which is visible at the following `done` within a few `tmo` windows. A corrupted status or logical-unit register changes the second byte of the sense command or the `result` and `sense_fail` values reported at `done` for that same command.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WSEL, S_WRDY, S_HOLD, S_WDMA, S_WDESEL
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_TMO = 2'd1,
    RES_ERR = 2'd2
  } seq_result_t;

  // phase code is {cd, io}
  localparam logic [1:0] PH_DOUT = 2'b00;
  localparam logic [1:0] PH_DIN  = 2'b01;
  localparam logic [1:0] PH_CMD  = 2'b10;
  localparam logic [1:0] PH_STAT = 2'b11;

  localparam int STAT_ERR_BIT = 1;
  localparam int STAT_LUN_LSB = 5;
endpackage

// File: rtl/dbs_wait_timer.sv
module dbs_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dbs_cmd_source.sv
module dbs_cmd_source #(
  parameter int          CMD_MAX   = 14,
  parameter int          CMD_SHORT = 6,
  parameter logic [7:0]  SENSE_OP  = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_user,
  input  logic                 long_sel,
  input  logic [CMD_MAX*8-1:0] user_bytes,
  input  logic                 load_sense,
  input  logic [2:0]           lun,
  input  logic                 advance,
  output logic [7:0]           next_byte
);
  localparam int IW    = $clog2(CMD_MAX + 1);
  localparam int DEPTH = 1 << IW;

  logic [7:0]    cmd_q [DEPTH];
  logic [IW-1:0] len_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (load_user) begin
      for (int i = 0; i < DEPTH; i++)
        cmd_q[i] <= (i < CMD_MAX) ? user_bytes[8*i +: 8] : 8'h00;
    end else if (load_sense) begin
      for (int i = 0; i < DEPTH; i++) cmd_q[i] <= 8'h00;
      cmd_q[0] <= SENSE_OP;
      cmd_q[1] <= {lun, 5'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      idx_q <= '0;
    end else if (load_user) begin
      len_q <= long_sel ? IW'(CMD_MAX) : IW'(CMD_SHORT);
      idx_q <= '0;
    end else if (load_sense) begin
      len_q <= IW'(CMD_SHORT);
      idx_q <= '0;
    end else if (advance && idx_q < len_q) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign next_byte = (idx_q < len_q) ? cmd_q[idx_q] : 8'h00;
endmodule

// File: rtl/dbs_sense_store.sv
module dbs_sense_store #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         wr,
  input  logic [7:0]   wdata,
  output logic [N*8-1:0] flat
);
  localparam int CW = $clog2(N + 1);

  logic [7:0]    byte_q [N];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      for (int i = 0; i < N; i++) byte_q[i] <= 8'h00;
    end else if (wr && cnt_q < CW'(N)) begin
      byte_q[cnt_q[$clog2(N)-1:0]] <= wdata;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign flat[8*g +: 8] = byte_q[g];
  end
endmodule

// File: rtl/disk_bus_sequencer.sv
module disk_bus_sequencer
  import dbs_pkg::*;
#(
  parameter int         CMD_MAX   = 14,
  parameter int         CMD_SHORT = 6,
  parameter int         TW        = 16,
  parameter int         SENSE_LEN = 4,
  parameter logic [7:0] SENSE_OP  = 8'h03
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   dma_mode,
  input  logic                   cmd_long,
  input  logic [CMD_MAX*8-1:0]   cmd_bytes,
  input  logic [TW-1:0]          tmo,
  input  logic                   src_en,
  input  logic [7:0]             src_byte,
  output logic                   src_take,
  input  logic                   sink_en,
  output logic [7:0]             sink_byte,
  output logic                   sink_valid,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             result,
  output logic                   sense_fail,
  output logic [SENSE_LEN*8-1:0] sense_data,
  output logic                   bus_sel,
  output logic                   bus_dma_en,
  output logic                   bus_wr,
  output logic [7:0]             bus_wdata,
  output logic                   bus_rd,
  input  logic [7:0]             bus_rdata,
  input  logic                   st_sel,
  input  logic                   st_rdy,
  input  logic                   st_cd,
  input  logic                   st_io,
  output logic                   dma_req,
  input  logic                   dma_irq
);
  seq_state_t  state, state_n;
  logic        dma_q, src_en_q, sink_en_q, in_sense;
  logic [7:0]  stat_q;
  logic [7:0]  cmd_byte;
  logic        tmr_exp, tmr_load;
  logic        use_dma;

  logic        go_sel, ld_user, ld_sense, wr_cmd, wr_dat, rd_dat, rd_stat;
  logic        dma_on, dma_off, fin, fin_sf, tmo_hit;
  seq_result_t fin_res;

  assign use_dma = dma_q && !in_sense;

  always_comb begin
    state_n = state;
    go_sel = 1'b0; ld_user = 1'b0; ld_sense = 1'b0;
    wr_cmd = 1'b0; wr_dat = 1'b0; rd_dat = 1'b0; rd_stat = 1'b0;
    dma_on = 1'b0; dma_off = 1'b0; fin = 1'b0; fin_sf = 1'b0;
    tmo_hit = 1'b0; fin_res = RES_OK;
    unique case (state)
      S_IDLE: if (start) begin
        state_n = S_WSEL; go_sel = 1'b1; ld_user = 1'b1;
      end
      S_WSEL: begin
        if (st_sel)       state_n = S_WRDY;
        else if (tmr_exp) tmo_hit = 1'b1;
      end
      S_WRDY: begin
        if (st_rdy) begin
          unique case ({st_cd, st_io})
            PH_CMD:  begin wr_cmd = 1'b1; state_n = S_HOLD; end
            PH_DOUT: if (use_dma) begin dma_on = 1'b1; state_n = S_WDMA; end
                     else begin wr_dat = 1'b1; state_n = S_HOLD; end
            PH_DIN:  if (use_dma) begin dma_on = 1'b1; state_n = S_WDMA; end
                     else begin rd_dat = 1'b1; state_n = S_HOLD; end
            default: begin rd_stat = 1'b1; state_n = S_WDESEL; end
          endcase
        end else if (tmr_exp) begin
          tmo_hit = 1'b1;
        end
      end
      S_HOLD: state_n = S_WRDY;
      S_WDMA: begin
        if (dma_irq)      begin dma_off = 1'b1; state_n = S_WRDY; end
        else if (tmr_exp) tmo_hit = 1'b1;
      end
      S_WDESEL: begin
        if (!st_sel) begin
          if (in_sense) begin
            fin = 1'b1; fin_res = RES_ERR; fin_sf = stat_q[STAT_ERR_BIT];
          end else if (stat_q[STAT_ERR_BIT]) begin
            ld_sense = 1'b1; go_sel = 1'b1; state_n = S_WSEL;
          end else begin
            fin = 1'b1; fin_res = RES_OK;
          end
        end else if (tmr_exp) begin
          tmo_hit = 1'b1;
        end
      end
      default: state_n = S_IDLE;
    endcase
    if (tmo_hit) begin
      fin     = 1'b1;
      fin_res = in_sense ? RES_ERR : RES_TMO;
      fin_sf  = in_sense;
    end
    if (fin) state_n = S_IDLE;
  end

  assign tmr_load = (state_n != state);

  dbs_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmo), .expired(tmr_exp)
  );

  dbs_cmd_source #(.CMD_MAX(CMD_MAX), .CMD_SHORT(CMD_SHORT), .SENSE_OP(SENSE_OP)) u_cmd (
    .clk(clk), .rst(rst), .load_user(ld_user), .long_sel(cmd_long),
    .user_bytes(cmd_bytes), .load_sense(ld_sense),
    .lun(stat_q[STAT_LUN_LSB +: 3]), .advance(wr_cmd), .next_byte(cmd_byte)
  );

  dbs_sense_store #(.N(SENSE_LEN)) u_sense (
    .clk(clk), .rst(rst), .clear(ld_user), .wr(rd_dat && in_sense),
    .wdata(bus_rdata), .flat(sense_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      dma_q      <= 1'b0;
      src_en_q   <= 1'b0;
      sink_en_q  <= 1'b0;
      in_sense   <= 1'b0;
      stat_q     <= 8'h00;
      bus_sel    <= 1'b0;
      bus_wr     <= 1'b0;
      bus_rd     <= 1'b0;
      bus_wdata  <= 8'h00;
      bus_dma_en <= 1'b0;
      dma_req    <= 1'b0;
      src_take   <= 1'b0;
      sink_valid <= 1'b0;
      sink_byte  <= 8'h00;
      done       <= 1'b0;
      result     <= RES_OK;
      sense_fail <= 1'b0;
    end else begin
      state      <= state_n;
      bus_sel    <= go_sel;
      bus_wr     <= wr_cmd || wr_dat;
      bus_rd     <= rd_dat || rd_stat;
      src_take   <= wr_dat && src_en_q && !in_sense;
      sink_valid <= rd_dat && sink_en_q && !in_sense;
      done       <= fin;
      if (wr_cmd)      bus_wdata <= cmd_byte;
      else if (wr_dat) bus_wdata <= (src_en_q && !in_sense) ? src_byte : 8'h00;
      if (rd_dat)  sink_byte <= bus_rdata;
      if (rd_stat) stat_q    <= bus_rdata;
      if (ld_user) begin
        dma_q      <= dma_mode;
        src_en_q   <= src_en;
        sink_en_q  <= sink_en;
        in_sense   <= 1'b0;
        bus_dma_en <= dma_mode;
        sense_fail <= 1'b0;
      end
      if (ld_sense) begin
        in_sense   <= 1'b1;
        bus_dma_en <= 1'b0;
      end
      if (dma_on)  dma_req <= 1'b1;
      if (dma_off) dma_req <= 1'b0;
      if (fin) begin
        result     <= fin_res;
        sense_fail <= fin_sf;
        in_sense   <= 1'b0;
        bus_dma_en <= 1'b0;
        dma_req    <= 1'b0;
      end
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/disk_bus_sequencer_chk.sv
module disk_bus_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       busy,
  input logic [1:0] result,
  input logic       sense_fail,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_dma_en,
  input logic       dma_req,
  input logic       src_take
);
  AST_ONE_BUS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_sel, bus_wr, bus_rd})); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11
  AST_DMA_REQ_MODE: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> bus_dma_en); // R7
  AST_DMA_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (!bus_wr && !bus_rd)); // R7
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'd3)); // R8
  AST_TMO_NO_SENSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'd1) |-> !sense_fail); // R10
  AST_SENSE_FAIL_IS_ERR: assert property (@(posedge clk) disable iff (rst)
    (done && sense_fail) |-> (result == 2'd2)); // R10
  AST_TAKE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    src_take |-> bus_wr); // R5
endmodule

bind disk_bus_sequencer disk_bus_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .busy(busy), .result(result),
  .sense_fail(sense_fail), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_dma_en(bus_dma_en), .dma_req(dma_req), .src_take(src_take)
);

// File: tb/disk_bus_sequencer_bench.sv
module disk_bus_sequencer_bench;
  localparam int CMD_MAX = 14;
  localparam int TW      = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, dma_mode, cmd_long, src_en, sink_en;
  logic [CMD_MAX*8-1:0] cmd_bytes;
  logic [TW-1:0] tmo;
  logic [7:0] src_byte;
  logic src_take, sink_valid, busy, done, sense_fail;
  logic [7:0] sink_byte;
  logic [1:0] result;
  logic [31:0] sense_data;
  logic bus_sel, bus_dma_en, bus_wr, bus_rd, dma_req;
  logic [7:0] bus_wdata, bus_rdata;
  logic st_sel, st_rdy, st_cd, st_io, dma_irq;

  disk_bus_sequencer u_disk_bus_sequencer (
    .clk(clk), .rst(rst), .start(start), .dma_mode(dma_mode), .cmd_long(cmd_long),
    .cmd_bytes(cmd_bytes), .tmo(tmo), .src_en(src_en), .src_byte(src_byte),
    .src_take(src_take), .sink_en(sink_en), .sink_byte(sink_byte),
    .sink_valid(sink_valid), .busy(busy), .done(done), .result(result),
    .sense_fail(sense_fail), .sense_data(sense_data), .bus_sel(bus_sel),
    .bus_dma_en(bus_dma_en), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .st_sel(st_sel), .st_rdy(st_rdy),
    .st_cd(st_cd), .st_io(st_io), .dma_req(dma_req), .dma_irq(dma_irq)
  );

  // controller model
  logic [1:0] scr_ph [0:47];
  logic [7:0] scr_b  [0:47];
  int nsc, hang_sel_on, hang_rdy_at;
  bit hang_desel;
  logic [7:0] wlog [0:63];
  logic [7:0] slog [0:15];
  int wn, sn, take_n, irq_n, sel_num, ptr, dv, cnt;
  bit saw_dma_en;

  always @(posedge clk) begin
    if (rst) begin
      st_sel <= 0; st_rdy <= 0; st_cd <= 0; st_io <= 0; bus_rdata <= 0; dma_irq <= 0;
      wn <= 0; sn <= 0; take_n <= 0; irq_n <= 0; sel_num <= 0; ptr <= 0; dv <= 0; cnt <= 0;
      saw_dma_en <= 0;
    end else begin
      dma_irq <= 0;
      if (bus_dma_en) saw_dma_en <= 1;
      if (bus_wr && wn < 64) begin wlog[wn] <= bus_wdata; wn <= wn + 1; end
      if (sink_valid && sn < 16) begin slog[sn] <= sink_byte; sn <= sn + 1; end
      if (src_take) take_n <= take_n + 1;
      case (dv)
        0: if (bus_sel) begin
             sel_num <= sel_num + 1; cnt <= 2;
             dv <= (sel_num + 1 == hang_sel_on) ? 7 : 1;
           end
        1: if (cnt == 0) begin st_sel <= 1; dv <= 2; end else cnt <= cnt - 1;
        2: if (ptr != hang_rdy_at && ptr < nsc) begin
             st_rdy <= 1; {st_cd, st_io} <= scr_ph[ptr]; bus_rdata <= scr_b[ptr]; dv <= 3;
           end
        3: if (bus_wr || bus_rd) begin
             st_rdy <= 0; ptr <= ptr + 1;
             if (bus_rd && scr_ph[ptr] == 2'b11) begin dv <= hang_desel ? 7 : 5; cnt <= 2; end
             else dv <= 2;
           end else if (dma_req) begin
             st_rdy <= 0; cnt <= 3; dv <= 4;
           end
        4: if (cnt == 0) begin dma_irq <= 1; irq_n <= irq_n + 1; ptr <= ptr + 1; dv <= 2; end
           else cnt <= cnt - 1;
        5: if (cnt == 0) begin st_sel <= 0; dv <= 0; end else cnt <= cnt - 1;
        default: ;
      endcase
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic add(input logic [1:0] ph, input logic [7:0] b);
    scr_ph[nsc] = ph; scr_b[nsc] = b; nsc++;
  endtask

  task automatic add_cmd(input int n);
    for (int i = 0; i < n; i++) add(2'b10, 8'h00);
  endtask

  task automatic setup();
    rst = 1; start = 0;
    nsc = 0; hang_sel_on = 0; hang_rdy_at = -1; hang_desel = 0;
    dma_mode = 0; cmd_long = 0; src_en = 1; sink_en = 1; tmo = 16'd8;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic run();
    int k;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    chk("R11 done seen", {31'd0, done}, 32'd1);
  endtask

  // rows: [23] long, [22:20] n_out, [19:17] n_in, [15:8] status
  localparam logic [23:0] VEC [4] = '{
    {1'b0, 3'd2, 3'd1, 1'b0, 8'h00, 8'h00},
    {1'b1, 3'd0, 3'd3, 1'b0, 8'hE0, 8'h00},
    {1'b0, 3'd0, 3'd0, 1'b0, 8'h01, 8'h00},
    {1'b1, 3'd3, 3'd0, 1'b0, 8'hFD, 8'h00}
  };

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    src_byte = 8'h5A;
    for (int i = 0; i < CMD_MAX; i++) cmd_bytes[8*i +: 8] = 8'h10 + 8'(i);
    setup();
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 strobes", {29'd0, bus_sel, bus_wr, bus_rd}, 0);
    chk("R1 dma", {30'd0, dma_req, bus_dma_en}, 0);
    chk("R1 sense_fail", {31'd0, sense_fail}, 0);

    // table walk: R4 R5 R6 R8 R12 (tmo 8 far below the command length)
    for (int r = 0; r < 4; r++) begin
      int len, no, ni, bad;
      setup();
      cmd_long = VEC[r][23];
      len = cmd_long ? 14 : 6;
      no = int'(VEC[r][22:20]); ni = int'(VEC[r][19:17]);
      add_cmd(len);
      for (int i = 0; i < no; i++) add(2'b00, 8'h00);
      for (int i = 0; i < ni; i++) add(2'b01, 8'hC0 + 8'(i));
      add(2'b11, VEC[r][15:8]);
      run();
      chk("R8 R12 result ok", {30'd0, result}, 32'd0);
      chk("R2 one select", sel_num, 1);
      chk("R4 byte count", wn, len + no);
      bad = 0;
      for (int i = 0; i < len; i++) if (wlog[i] !== 8'h10 + 8'(i)) bad++;
      for (int i = 0; i < no; i++) if (wlog[len+i] !== 8'h5A) bad++;
      chk("R4 R5 bytes sent", bad, 0);
      chk("R5 take count", take_n, no);
      chk("R6 sink count", sn, ni);
      bad = 0;
      for (int i = 0; i < ni; i++) if (slog[i] !== 8'hC0 + 8'(i)) bad++;
      chk("R6 sink bytes", bad, 0);
    end

    // R4 command phases beyond length send zero
    setup();
    add_cmd(8); add(2'b11, 8'h00);
    run();
    chk("R4 last real byte", {24'd0, wlog[5]}, 32'h15);
    chk("R4 extra byte zero", {16'd0, wlog[6], wlog[7]}, 0);

    // R5 no source -> zero byte, no take
    setup();
    src_en = 0;
    add_cmd(6); add(2'b00, 0); add(2'b00, 0); add(2'b11, 8'h00);
    run();
    chk("R5 zero bytes", {16'd0, wlog[6], wlog[7]}, 0);
    chk("R5 no take", take_n, 0);

    // R6 no sink -> discard
    setup();
    sink_en = 0;
    add_cmd(6); add(2'b01, 8'h77); add(2'b01, 8'h78); add(2'b11, 8'h00);
    run();
    chk("R6 discard no pulse", sn, 0);
    chk("R6 discard result", {30'd0, result}, 0);

    // R7 DMA data phases
    setup();
    dma_mode = 1;
    add_cmd(6); add(2'b00, 0); add(2'b01, 0); add(2'b11, 8'h00);
    run();
    chk("R7 result", {30'd0, result}, 0);
    chk("R7 no strobe for data", wn, 6);
    chk("R7 irq count", irq_n, 2);
    chk("R2 mode driven", {31'd0, saw_dma_en}, 1);

    // R2 select timeout
    setup();
    hang_sel_on = 1; add_cmd(6); add(2'b11, 0);
    run();
    chk("R2 select timeout", {30'd0, result}, 1);
    chk("R10 tmo no sense flag", {31'd0, sense_fail}, 0);

    // R3 ready timeout
    setup();
    hang_rdy_at = 3; add_cmd(6); add(2'b11, 0);
    run();
    chk("R3 ready timeout", {30'd0, result}, 1);
    chk("R3 bytes before stall", wn, 3);

    // R8 deselect timeout
    setup();
    hang_desel = 1; add_cmd(6); add(2'b11, 0);
    run();
    chk("R8 deselect timeout", {30'd0, result}, 1);

    // R9 automatic sense
    setup();
    add_cmd(6); add(2'b11, 8'h62);
    add_cmd(6);
    add(2'b01, 8'hA1); add(2'b01, 8'hA2); add(2'b01, 8'hA3); add(2'b01, 8'hA4);
    add(2'b11, 8'h00);
    run();
    chk("R9 result err", {30'd0, result}, 2);
    chk("R9 sense ok", {31'd0, sense_fail}, 0);
    chk("R9 sense bytes", sense_data, 32'hA4A3A2A1);
    chk("R9 sense opcode", {24'd0, wlog[6]}, 32'h03);
    chk("R9 sense lun", {24'd0, wlog[7]}, 32'h60);
    chk("R9 sense tail zero", {wlog[8], wlog[9], wlog[10], wlog[11]}, 0);
    chk("R9 sense not to sink", sn, 0);
    chk("R9 reselect", sel_num, 2);
    // R11 done one cycle
    @(negedge clk);
    chk("R11 done single", {31'd0, done}, 0);
    chk("R11 idle after", {31'd0, busy}, 0);

    // R10 sense times out
    setup();
    hang_sel_on = 2; add_cmd(6); add(2'b11, 8'h22);
    run();
    chk("R10 sense tmo result", {30'd0, result}, 2);
    chk("R10 sense tmo flag", {31'd0, sense_fail}, 1);

    // R10 sense reports error: no second sense
    setup();
    add_cmd(6); add(2'b11, 8'h02);
    add_cmd(6); add(2'b11, 8'h02);
    add_cmd(6); add(2'b11, 8'h00);
    run();
    chk("R10 sense err result", {30'd0, result}, 2);
    chk("R10 sense err flag", {31'd0, sense_fail}, 1);
    chk("R10 no nesting", sel_num, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule